// File: doc/BRIEF.md
# 12-bit Word-Addressed Instruction Sequencer

This core runs programs for a 12-bit, word-addressed minicomputer with a 4096-word address space. It talks to one synchronous single-port memory. The memory interface has an address, write data, a write strobe and read data. Read data is valid in the cycle after the address is presented. The architectural state is a 12-bit accumulator, a single link bit and a 12-bit program counter.

Each instruction word splits as follows:
- bits 11..9: opcode
- bit 8: indirect flag
- bit 7: page select
- bits 6..0: a 7-bit offset

The six memory-reference opcodes take an effective address from page zero or the current page. That address can go through one level of indirection, and some page-zero pointers increment automatically. Opcode 6 (the I/O transfer) is accepted and does nothing. Opcode 7 runs a short operate sequence on the accumulator and link.

Control is built from five generic states:
- fetch
- operand-address calculation
- pointer fetch
- execute, which repeats for the operate sequence
- a deferred write-back of the incremented pointer

A level-sensitive run input lets the core proceed from fetch. A halt instruction parks the core until run has been dropped and raised again.

Top module: `mc12_core`

## Requirements
- R1: While rst_n is low, and afterwards until run is raised, acc, link and pc read zero, idle reads 1 and mem_we stays 0.
- R2: With bit 7 clear, the effective address is the 7-bit offset in page zero. With bit 7 set, it is the upper five bits of the instruction's own address followed by the offset.
- R3: With bit 8 set on opcodes 0 to 5, the word at the effective address is read and used as the operand address. A pointer outside the auto-increment window is left unchanged in memory.
- R4: An indirect reference through page-zero locations 8 to 15 (octal 0010 to 0017) increments the pointer first and uses the new value as the operand address. It writes that value back to the pointer location after the operand access, even when the execute step itself writes memory.
- R5: Opcode 0 ANDs the operand into acc and leaves link unchanged.
- R6: Opcode 1 adds the operand to acc modulo 4096 and inverts link when the addition carries out of bit 11.
- R7: Opcode 2 increments the operand, writes it back, and skips the next instruction when the result is zero.
- R8: Opcode 3 writes acc to the effective address and then clears acc.
- R9: Opcode 5 loads pc with the effective address. Opcode 4 stores the return address (instruction address plus one) at the effective address and continues at the effective address plus one.
- R10: Opcode 7 with bit 8 clear applies its options in this order. Bit 7 clears acc and bit 6 clears link. Next, bit 5 inverts acc and bit 4 inverts link. Last, bit 0 increments the 13-bit value {link, acc}. Execute repeats only for this opcode.
- R11: Opcode 7 with bits 8 and 1 set (octal 7402) halts the core in fetch with idle high and state frozen, even with run high. Dropping run and raising it again resumes at the next instruction.
- R12: Opcode 6 changes neither acc, link nor memory, and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Level enable; the core leaves fetch only while high |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 12 | Memory read data, one cycle after the address |
| acc | output | 12 | Accumulator |
| link | output | 1 | Link bit |
| pc | output | 12 | Program counter |
| idle | output | 1 | High while parked in fetch and not allowed to proceed |

## Verification
The hardest case to reach is the auto-increment pointer write-back coming after an execute step that writes memory itself. In that case two writes leave the core in consecutive cycles, to different addresses. The stimulus loads a program that deposits the accumulator through a page-zero pointer inside the window. It then checks both the stored operand and the advanced pointer. Sweeps of the pointer location across both window edges separate the incrementing locations from their neighbours. A second hard case is the zero-result skip. It is reached by seeding the counted word with all ones and with values either side of it.

// File: rtl/mc12_pkg.sv
package mc12_pkg;
  localparam int WORD_W = 12;
  localparam int OFF_W  = 7;
  localparam int PAGE_W = WORD_W - OFF_W;
  localparam int OP_MSB = WORD_W - 1;
  localparam int IND_BIT = 8;
  localparam int PAGE_BIT = 7;
  // operate field positions
  localparam int GRP_BIT = 8;
  localparam int CLA_BIT = 7;
  localparam int CLL_BIT = 6;
  localparam int CMA_BIT = 5;
  localparam int CML_BIT = 4;
  localparam int HLT_BIT = 1;
  localparam int IAC_BIT = 0;
  localparam logic [1:0] OPR_LAST = 2'd2;

  typedef enum logic [2:0] {
    ST_F0, ST_F1, ST_F2, ST_E0, ST_E1
  } state_e;

  typedef enum logic [2:0] {
    OP_AND = 3'd0, OP_TAD = 3'd1, OP_ISZ = 3'd2, OP_DCA = 3'd3,
    OP_JMS = 3'd4, OP_JMP = 3'd5, OP_IOT = 3'd6, OP_OPR = 3'd7
  } opcode_e;
endpackage

// File: rtl/mc12_ea.sv
module mc12_ea import mc12_pkg::*; #(
  parameter int AI_BASE  = 8,
  parameter int AI_COUNT = 8
) (
  input  logic [IND_BIT:0]      word,
  input  logic [PAGE_W-1:0]     pc_page,
  output logic [WORD_W-1:0]     ea,
  output logic                  ai_hit
);
  localparam int AI_LAST = AI_BASE + AI_COUNT - 1;

  logic [OFF_W-1:0] off;
  assign off = word[OFF_W-1:0];
  assign ea  = word[PAGE_BIT] ? {pc_page, off} : {{PAGE_W{1'b0}}, off};

  generate
    if (AI_COUNT > 0) begin : g_ai
      assign ai_hit = word[IND_BIT] && !word[PAGE_BIT] &&
                      (32'(off) >= AI_BASE) && (32'(off) <= AI_LAST);
    end else begin : g_no_ai
      assign ai_hit = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mc12_opr.sv
module mc12_opr import mc12_pkg::*; (
  input  logic [1:0]        step,
  input  logic              grp,
  input  logic              cla,
  input  logic              cll,
  input  logic              cma,
  input  logic              cml,
  input  logic              iac,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              link_i,
  output logic [WORD_W-1:0] acc_o,
  output logic              link_o
);
  always_comb begin
    acc_o  = acc_i;
    link_o = link_i;
    case (step)
      2'd0: begin
        if (cla) acc_o = '0;
        if (!grp && cll) link_o = 1'b0;
      end
      2'd1: begin
        if (!grp && cma) acc_o = ~acc_i;
        if (!grp && cml) link_o = ~link_i;
      end
      2'd2: begin
        if (!grp && iac) {link_o, acc_o} = {link_i, acc_i} + 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mc12_seq.sv
module mc12_seq import mc12_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  opcode_e op,
  input  logic    ind,
  input  logic    ai_pend,
  input  logic    hlt_req,
  output state_e  state,
  output logic [1:0] step,
  output logic    go
);
  state_e     state_n;
  logic [1:0] step_n;
  logic       lock_q, lock_n;

  assign go = run && !lock_q;

  always_comb begin
    state_n = state;
    step_n  = '0;
    case (state)
      ST_F0: if (go) state_n = ST_F1;
      ST_F1: begin
        if (op == OP_OPR || op == OP_IOT) state_n = ST_E0;
        else if (ind)                     state_n = ST_F2;
        else                              state_n = ST_E0;
      end
      ST_F2: state_n = ST_E0;
      ST_E0: begin
        if (op == OP_OPR && step != OPR_LAST) begin
          state_n = ST_E0;
          step_n  = step + 1'b1;
        end else if (ai_pend) begin
          state_n = ST_E1;
        end else begin
          state_n = ST_F0;
        end
      end
      ST_E1: state_n = ST_F0;
      default: state_n = ST_F0;
    endcase
  end

  always_comb begin
    if (hlt_req)   lock_n = 1'b1;
    else if (!run) lock_n = 1'b0;
    else           lock_n = lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_F0;
      step   <= '0;
      lock_q <= 1'b0;
    end else begin
      state  <= state_n;
      step   <= step_n;
      lock_q <= lock_n;
    end
  end

  // R3
  ind_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F2) |-> ($past(state) == ST_F1));

  // R4
  ai_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_E1) |-> ($past(state) == ST_E0));

  // R10
  opr_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_E0 && $past(state) == ST_E0) |-> (op == OP_OPR));

  // R11
  hlt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlt_req |=> (state == ST_F0 && !go));
endmodule

// File: rtl/mc12_core.sv
module mc12_core import mc12_pkg::*; #(
  parameter int AI_BASE  = 8,
  parameter int AI_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] acc,
  output logic              link,
  output logic [WORD_W-1:0] pc,
  output logic              idle
);
  state_e            state;
  logic [1:0]        step;
  logic              go;
  logic [WORD_W-1:0] ir_q, ea_q, ea_dir, ptr_n, isz_val;
  logic [WORD_W-1:0] acc_n, pc_n, ea_n, ir_n, opr_acc;
  logic              link_n, ai_q, ai_n, ai_hit, opr_link, hlt_req, ir_ld;
  logic              cur_ind;
  logic [WORD_W:0]   tad_sum;
  opcode_e           cur_op;

  // in F1 the instruction is still on the read bus; later it sits in ir_q
  assign cur_op  = opcode_e'((state == ST_F1) ? mem_rdata[OP_MSB -: 3] : ir_q[OP_MSB -: 3]);
  assign cur_ind = (state == ST_F1) ? mem_rdata[IND_BIT] : ir_q[IND_BIT];
  assign ptr_n   = ai_q ? mem_rdata + 1'b1 : mem_rdata;
  assign isz_val = mem_rdata + 1'b1;
  assign tad_sum = {1'b0, acc} + {1'b0, mem_rdata};
  assign hlt_req = (state == ST_E0) && (cur_op == OP_OPR) && ir_q[GRP_BIT] &&
                   ir_q[HLT_BIT] && (step == OPR_LAST);
  assign idle    = (state == ST_F0) && !go;
  assign ir_ld   = (state == ST_F1);

  mc12_seq u_seq (
    .clk, .rst_n, .run, .op(cur_op), .ind(cur_ind), .ai_pend(ai_q),
    .hlt_req, .state, .step, .go
  );

  mc12_ea #(.AI_BASE(AI_BASE), .AI_COUNT(AI_COUNT)) u_ea (
    .word(mem_rdata[IND_BIT:0]), .pc_page(pc[WORD_W-1:OFF_W]),
    .ea(ea_dir), .ai_hit
  );

  mc12_opr u_opr (
    .step, .grp(ir_q[GRP_BIT]), .cla(ir_q[CLA_BIT]), .cll(ir_q[CLL_BIT]),
    .cma(ir_q[CMA_BIT]), .cml(ir_q[CML_BIT]), .iac(ir_q[IAC_BIT]),
    .acc_i(acc), .link_i(link), .acc_o(opr_acc), .link_o(opr_link)
  );

  always_comb begin
    acc_n = acc;  link_n = link;  pc_n = pc;
    ir_n  = mem_rdata;  ea_n = ea_q;  ai_n = ai_q;
    mem_addr = pc;  mem_wdata = acc;  mem_we = 1'b0;
    case (state)
      ST_F0: ai_n = 1'b0;
      ST_F1: begin
        pc_n     = pc + 1'b1;
        ea_n     = ea_dir;
        ai_n     = ai_hit && (cur_op != OP_IOT) && (cur_op != OP_OPR);
        mem_addr = ea_dir;
      end
      ST_F2: begin
        ea_n     = ptr_n;
        mem_addr = ptr_n;
      end
      ST_E0: begin
        mem_addr = ea_q;
        case (cur_op)
          OP_AND: acc_n = acc & mem_rdata;
          OP_TAD: begin
            acc_n  = tad_sum[WORD_W-1:0];
            link_n = link ^ tad_sum[WORD_W];
          end
          OP_ISZ: begin
            mem_we    = 1'b1;
            mem_wdata = isz_val;
            if (isz_val == '0) pc_n = pc + 1'b1;
          end
          OP_DCA: begin
            mem_we    = 1'b1;
            mem_wdata = acc;
            acc_n     = '0;
          end
          OP_JMS: begin
            mem_we    = 1'b1;
            mem_wdata = pc;
            pc_n      = ea_q + 1'b1;
          end
          OP_JMP: pc_n = ea_q;
          OP_OPR: begin
            acc_n  = opr_acc;
            link_n = opr_link;
          end
          default: ;
        endcase
      end
      ST_E1: begin
        mem_addr  = {{PAGE_W{1'b0}}, ir_q[OFF_W-1:0]};
        mem_wdata = ea_q;
        mem_we    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      link <= 1'b0;
      pc   <= '0;
      ir_q <= '0;
      ea_q <= '0;
      ai_q <= 1'b0;
    end else begin
      acc  <= acc_n;
      link <= link_n;
      pc   <= pc_n;
      ea_q <= ea_n;
      ai_q <= ai_n;
      if (ir_ld) ir_q <= ir_n;
    end
  end

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ($stable(pc) && $stable(acc) && $stable(link)));

  // R8
  wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state == ST_E0 || state == ST_E1));

  // R7
  isz_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_E0 && cur_op == OP_ISZ && mem_rdata == '1) |=> (pc == $past(pc) + 1'b1));

  // R4
  ai_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_E1) |-> (mem_we && mem_addr[WORD_W-1:OFF_W] == '0));
endmodule

// File: tb/mc12_core_tb_top.sv
`timescale 1ns/1ps
module mc12_core_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, run, mem_we, link, idle;
  logic [11:0] mem_addr, mem_wdata, mem_rdata, acc, pc;
  logic [11:0] mem [4096];
  int tests = 0;
  int fails = 0;

  mc12_core dut_i (
    .clk, .rst_n, .run, .mem_addr, .mem_wdata, .mem_we, .mem_rdata,
    .acc, .link, .pc, .idle
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic clr();
    foreach (mem[i]) mem[i] = 12'd0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    repeat (2) @(negedge clk);
    while (!idle && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (!idle) begin
      tests++;
      fails++;
      $display("FAIL R11 core never halted actual=%0d expected=1", idle);
    end
  endtask

  task automatic go_prog();
    rst_n = 1'b0;
    run   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;
    wait_idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a, b, s, v, m, bits, ea, el, t, x;
    int xs [5];
    xs = '{0, 1, 12'o7776, 12'o7777, 12'o4000};
    rst_n = 1'b0;
    run   = 1'b0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 pc", pc, 0);
    chk("R1 acc", acc, 0);
    chk("R1 link", link, 0);
    chk("R1 idle", idle, 1);
    chk("R1 mem_we", mem_we, 0);

    // R5 R6: sweep of operand pairs through page-zero direct references (R2)
    for (int i = 0; i < 150; i++) begin
      a = (i * 1237 + 11) & 12'hfff;
      b = (i * 2731 + 5) & 12'hfff;
      if (i == 0) begin a = 12'hfff; b = 1; end
      clr();
      mem[0] = 12'o1040; mem[1] = 12'o1041; mem[2] = 12'o7402;
      mem[32] = 12'(a); mem[33] = 12'(b);
      go_prog();
      s = a + b;
      chk("R6 sum", acc, s & 12'hfff);
      chk("R6 link", link, (s >> 12) & 1);
      clr();
      mem[0] = 12'o1040; mem[1] = 12'o0041; mem[2] = 12'o7402;
      mem[32] = 12'(a); mem[33] = 12'(b);
      go_prog();
      chk("R5 and", acc, a & b);
      chk("R5 link", link, 0);
    end

    // R10: every option combination with link both clear and set
    for (int lin = 0; lin < 2; lin++) begin
      for (int mi = 0; mi < 32; mi++) begin
        m = mi;
        v = (m % 3 == 0) ? 12'hfff : ((m * 12'o521 + lin * 12'o17) & 12'hfff);
        bits = ((m & 1) ? 12'o200 : 0) | ((m & 2) ? 12'o100 : 0) |
               ((m & 4) ? 12'o040 : 0) | ((m & 8) ? 12'o020 : 0) |
               ((m & 16) ? 12'o001 : 0);
        clr();
        mem[0] = 12'o1040;
        mem[1] = (lin != 0) ? 12'o7020 : 12'o7000;
        mem[2] = 12'(12'o7000 | bits);
        mem[3] = 12'o7402;
        mem[32] = 12'(v);
        go_prog();
        ea = v; el = lin;
        if ((m & 1) != 0) ea = 0;
        if ((m & 2) != 0) el = 0;
        if ((m & 4) != 0) ea = (~ea) & 12'hfff;
        if ((m & 8) != 0) el = 1 - el;
        if ((m & 16) != 0) begin
          t = ((el << 12) | ea) + 1;
          ea = t & 12'hfff;
          el = (t >> 12) & 1;
        end
        chk("R10 acc", acc, ea);
        chk("R10 link", link, el);
      end
    end

    // R7: increment, write back, skip only on zero
    foreach (xs[k]) begin
      x = xs[k];
      clr();
      mem[0] = 12'o2040; mem[1] = 12'o7402; mem[2] = 12'o1041; mem[3] = 12'o7402;
      mem[32] = 12'(x); mem[33] = 12'd5;
      go_prog();
      chk("R7 mem", mem[32], (x + 1) & 12'hfff);
      chk("R7 acc", acc, (x == 12'hfff) ? 5 : 0);
      chk("R7 pc", pc, (x == 12'hfff) ? 4 : 2);
    end

    // R8: deposit and clear
    for (int i = 0; i < 8; i++) begin
      v = (i * 12'o1111 + 3) & 12'hfff;
      clr();
      mem[0] = 12'o1040; mem[1] = 12'o3041; mem[2] = 12'o7402;
      mem[32] = 12'(v);
      go_prog();
      chk("R8 mem", mem[33], v);
      chk("R8 acc", acc, 0);
    end

    // R9: subroutine call and indirect return jump
    clr();
    mem[0] = 12'o4050; mem[1] = 12'o7402;
    mem[12'o51] = 12'o1040; mem[12'o52] = 12'o5450;
    mem[32] = 12'o123;
    go_prog();
    chk("R9 return addr", mem[12'o50], 1);
    chk("R9 acc", acc, 12'o123);
    chk("R9 pc", pc, 2);

    // R2 R3: current-page indirect operand, pointer at 1741 holds 1001
    clr();
    mem[0] = 12'o5460; mem[12'o60] = 12'o1743;
    mem[12'o1743] = 12'o1741; mem[12'o1744] = 12'o7402;
    mem[12'o1741] = 12'o1001; mem[12'o1001] = 12'o5212;
    go_prog();
    chk("R3 acc", acc, 12'o5212);
    chk("R3 pc", pc, 12'o1745);
    chk("R3 pointer kept", mem[12'o1741], 12'o1001);

    // R2: current-page and page-zero direct references with the same offset
    clr();
    mem[0] = 12'o5460; mem[12'o60] = 12'o2000;
    mem[12'o2000] = 12'o1205; mem[12'o2001] = 12'o1005; mem[12'o2002] = 12'o7402;
    mem[12'o2005] = 12'o1234; mem[5] = 12'o0001;
    go_prog();
    chk("R2 acc", acc, 12'o1235);
    chk("R3 pointer kept page0", mem[12'o60], 12'o2000);

    // R4: pointer locations across both window edges
    for (int loc = 7; loc <= 16; loc++) begin
      clr();
      mem[0] = 12'(12'o1400 + loc); mem[1] = 12'o7402;
      mem[loc] = 12'o300; mem[12'o300] = 12'd1; mem[12'o301] = 12'd2;
      go_prog();
      chk("R4 acc", acc, (loc >= 8 && loc <= 15) ? 2 : 1);
      chk("R4 pointer", mem[loc], (loc >= 8 && loc <= 15) ? 12'o301 : 12'o300);
    end

    // R4 R8: deposit through an incrementing pointer, two writes back to back
    clr();
    mem[0] = 12'o1040; mem[1] = 12'o3411; mem[2] = 12'o7402;
    mem[12'o11] = 12'o177; mem[32] = 12'o4321;
    go_prog();
    chk("R4 stored operand", mem[12'o200], 12'o4321);
    chk("R4 pointer advanced", mem[12'o11], 12'o200);
    chk("R8 acc cleared", acc, 0);

    // R12: transfer opcode is a no-op
    clr();
    mem[0] = 12'o6031; mem[1] = 12'o1040; mem[2] = 12'o7402;
    mem[32] = 12'o77;
    go_prog();
    chk("R12 acc", acc, 12'o77);
    chk("R12 link", link, 0);
    chk("R12 pc", pc, 3);
    chk("R12 mem", mem[32], 12'o77);

    // R11: halt holds with run high, resumes after run toggles
    clr();
    mem[0] = 12'o7402; mem[1] = 12'o1040; mem[2] = 12'o7402;
    mem[32] = 12'o555;
    go_prog();
    chk("R11 pc at halt", pc, 1);
    chk("R11 acc at halt", acc, 0);
    repeat (10) @(negedge clk);
    chk("R11 pc held", pc, 1);
    chk("R11 idle held", idle, 1);
    run = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    wait_idle();
    chk("R11 resumed acc", acc, 12'o555);
    chk("R11 resumed pc", pc, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule